// File: doc/BRIEF.md
# Encoder Counter Register and Interrupt Unit

This block gives software a small memory-mapped view of a quadrature encoder counter. It keeps a 16-bit control word that configures the counter core, a 5-bit sticky status word that records events reported by the core, and a 32-bit shared data word. Software writes a preload value into the data word, and the data word also receives snapshots of the live count. All status flags that have their enable bit set are merged into one level interrupt.

The bus is synchronous: the address, the write enable and the write data are sampled on a rising clock edge. A write takes effect at that edge. The read data for the sampled address is registered at the same edge.

Two control bits are one-shot commands rather than stored settings:
- Control bit 5 requests a preload. The block pulses `preloadPulse` for one cycle, and the counter core loads `preloadValue`.
- Control bit 8 requests a latch. The data word is overwritten with `liveCount` at the write edge.

The counter core reports events on `eventIn`. Each bit is held high for every cycle its condition is present.

Top module: `encoder_reg_irq`

## Requirements
- R1: After reset, the control word (offset 0x00), the status word (offset 0x04) and the data word (offset 0x08) all read 0, and `irq` is 0.
- R2: A write to offset 0x00 stores control bits 0-4, 6-7 and 9-15 as written. These bits read back unchanged and appear on `cfgOut`. Control bits 5 and 8 always read 0, and bits 31:16 of that offset always read 0.
- R3: A control write with bit 5 set drives `preloadPulse` high for exactly the one cycle after the write edge. During that cycle, `preloadValue` carries the data word.
- R4: A control write with bit 8 set loads the data word with `liveCount` as sampled at the write edge.
- R5: A write to offset 0x08 stores the full 32-bit value, which reads back unchanged.
- R6: Status bits are 0 quadrature error, 1 overflow, 2 underflow, 3 index event, 4 compare match. A high `eventIn[i]` sets status bit i whatever its interrupt enable. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R8: `irq` is high exactly while some status bit and its enable are both 1. The enables are: status bit 0 uses control bit 12, bit 1 uses control bit 7, bit 2 uses control bit 6, bit 3 uses control bit 4, and bit 4 uses control bit 15. `irq` follows the flags with no added delay.
- R9: While `eventIn[3]` stays high, clearing status bit 3 has no lasting effect, so `irq` stays high if control bit 4 is set.
- R10: When control bit 13 is set, each cycle with `eventIn[3]` high loads the data word with `liveCount`. When control bit 13 is clear, `eventIn[3]` leaves the data word unchanged.
- R11: Offsets other than 0x00, 0x04 and 0x08 read 0, and writes to them change no register.
- R12: `busRdata` shows the register selected by the address one cycle after that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 4 | Byte offset of the register accessed |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| liveCount | input | 32 | Current count from the counter core |
| eventIn | input | 5 | Event conditions from the core, in status bit order |
| cfgOut | output | 16 | Stored control word to the core; strobe positions are 0 |
| preloadPulse | output | 1 | One-cycle preload command to the core |
| preloadValue | output | 32 | Data word, used as the preload value |
| irq | output | 1 | Level interrupt |

## Verification
The cycle at which each result is due is fixed:
- Register writes, snapshots and status flag changes land on the edge that samples the write or the event.
- `irq` and `cfgOut` change at that same edge.
- `preloadPulse` is high in the cycle that follows the write edge.
- `busRdata` shows the selected register one edge after the address is presented.

The bench drives every input on a falling edge and samples on the next falling edge, so each check looks at the first cycle in which its result is due. For the one-cycle pulse, the bench also looks one cycle later to confirm the pulse has ended.

// File: rtl/enc_regs_pkg.sv
package enc_regs_pkg;
  localparam int CTRL_W = 16;
  localparam int STAT_W = 5;

  // Control bit positions with behaviour inside this block
  localparam int CB_PRELOAD = 5;
  localparam int CB_LATCH   = 8;
  localparam int CB_IDX_RD  = 13;

  // Status bit positions
  localparam int SB_QERR  = 0;
  localparam int SB_OVER  = 1;
  localparam int SB_UNDER = 2;
  localparam int SB_INDEX = 3;
  localparam int SB_MATCH = 4;

  localparam logic [CTRL_W-1:0] STROBE_MASK =
    CTRL_W'((1 << CB_PRELOAD) | (1 << CB_LATCH));

  typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_STAT, SEL_DATA} regSel_t;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrStat;
    logic    wrData;
    logic    preloadCmd;
    logic    latchCmd;
    regSel_t rdSel;
  } busCmd_t;

  // Control bit that enables the interrupt of each status bit
  function automatic int enBitFor(input int statBit);
    case (statBit)
      SB_QERR:  return 12;
      SB_OVER:  return 7;
      SB_UNDER: return 6;
      SB_INDEX: return 4;
      default:  return 15;
    endcase
  endfunction
endpackage

// File: rtl/enc_regs_ctrl.sv
module enc_regs_ctrl
  import enc_regs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output busCmd_t           cmd
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(8);

  regSel_t sel;

  always_comb begin
    case (busAddr)
      OFF_CTRL: sel = SEL_CTRL;
      OFF_STAT: sel = SEL_STAT;
      OFF_DATA: sel = SEL_DATA;
      default:  sel = SEL_NONE;
    endcase
  end

  always_comb begin
    cmd.rdSel      = sel;
    cmd.wrCtrl     = busWe && (sel == SEL_CTRL);
    cmd.wrStat     = busWe && (sel == SEL_STAT);
    cmd.wrData     = busWe && (sel == SEL_DATA);
    cmd.preloadCmd = cmd.wrCtrl && busWdata[CB_PRELOAD];
    cmd.latchCmd   = cmd.wrCtrl && busWdata[CB_LATCH];
  end
endmodule

// File: rtl/enc_regs_dp.sv
module enc_regs_dp
  import enc_regs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  busCmd_t           cmd,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] liveCount,
  input  logic [STAT_W-1:0] eventIn,
  output logic [DATA_W-1:0] busRdata,
  output logic [CTRL_W-1:0] cfgOut,
  output logic              preloadPulse,
  output logic [DATA_W-1:0] preloadValue,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrlQ;
  logic [STAT_W-1:0] statusQ;
  logic [DATA_W-1:0] dataQ;
  logic [STAT_W-1:0] clearMask;
  logic [STAT_W-1:0] pending;
  logic              capture;

  assign clearMask = cmd.wrStat ? busWdata[STAT_W-1:0] : '0;
  assign capture   = cmd.latchCmd || (eventIn[SB_INDEX] && ctrlQ[CB_IDX_RD]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlQ        <= '0;
      statusQ      <= '0;
      dataQ        <= '0;
      preloadPulse <= 1'b0;
      busRdata     <= '0;
    end else begin
      if (cmd.wrCtrl) ctrlQ <= busWdata[CTRL_W-1:0] & ~STROBE_MASK;
      // events override a simultaneous clear
      statusQ <= (statusQ & ~clearMask) | eventIn;
      if (capture)         dataQ <= liveCount;
      else if (cmd.wrData) dataQ <= busWdata;
      preloadPulse <= cmd.preloadCmd;
      case (cmd.rdSel)
        SEL_CTRL: busRdata <= DATA_W'(ctrlQ);
        SEL_STAT: busRdata <= DATA_W'(statusQ);
        SEL_DATA: busRdata <= dataQ;
        default:  busRdata <= '0;
      endcase
    end
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_pend
    assign pending[i] = statusQ[i] & ctrlQ[enBitFor(i)];
  end

  assign irq          = |pending;
  assign cfgOut       = ctrlQ;
  assign preloadValue = dataQ;
endmodule

// File: rtl/encoder_reg_irq.sv
module encoder_reg_irq
  import enc_regs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] liveCount,
  input  logic [STAT_W-1:0] eventIn,
  output logic [CTRL_W-1:0] cfgOut,
  output logic              preloadPulse,
  output logic [DATA_W-1:0] preloadValue,
  output logic              irq
);
  busCmd_t cmd;

  enc_regs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busWdata(busWdata),
    .cmd     (cmd)
  );

  enc_regs_dp #(.DATA_W(DATA_W)) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .busWdata    (busWdata),
    .liveCount   (liveCount),
    .eventIn     (eventIn),
    .busRdata    (busRdata),
    .cfgOut      (cfgOut),
    .preloadPulse(preloadPulse),
    .preloadValue(preloadValue),
    .irq         (irq)
  );
endmodule

// File: rtl/enc_regs_chk.sv
module enc_regs_chk
  import enc_regs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [DATA_W-1:0] liveCount,
  input logic [STAT_W-1:0] eventIn,
  input logic              preloadPulse,
  input logic [DATA_W-1:0] preloadValue,
  input logic              irq,
  input logic [STAT_W-1:0] statusQ
);
  logic ctrlWrite, unmapped;
  assign ctrlWrite = busWe && (busAddr == ADDR_W'(0));
  assign unmapped  = (busAddr != ADDR_W'(0)) && (busAddr != ADDR_W'(4)) &&
                     (busAddr != ADDR_W'(8));

  assert_strobes_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == ADDR_W'(0)) |=> (busRdata[CB_PRELOAD] == 1'b0 &&
      busRdata[CB_LATCH] == 1'b0 && busRdata[DATA_W-1:CTRL_W] == '0));

  assert_preload_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWrite && busWdata[CB_PRELOAD]) |=> preloadPulse);

  assert_preload_only_on_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrlWrite && busWdata[CB_PRELOAD]) |=> !preloadPulse);

  assert_latch_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWrite && busWdata[CB_LATCH]) |=> (preloadValue == $past(liveCount)));

  // R7: the flag is set after an event even if cleared in that cycle
  assert_event_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eventIn != '0) |=> ((statusQ & $past(eventIn)) == $past(eventIn)));

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (statusQ == '0) |-> !irq);

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |=> (busRdata == '0));
endmodule

bind encoder_reg_irq enc_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busAddr     (busAddr),
  .busWe       (busWe),
  .busWdata    (busWdata),
  .busRdata    (busRdata),
  .liveCount   (liveCount),
  .eventIn     (eventIn),
  .preloadPulse(preloadPulse),
  .preloadValue(preloadValue),
  .irq         (irq),
  .statusQ     (u_data.statusQ)
);

// File: tb/encoder_reg_irq_bench.sv
`timescale 1ns/1ps
module encoder_reg_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] liveCount = '0;
  logic [4:0]  eventIn = '0;
  logic [15:0] cfgOut;
  logic        preloadPulse;
  logic [31:0] preloadValue;
  logic        irq;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  encoder_reg_irq u_encoder_reg_irq (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .liveCount(liveCount),
    .eventIn(eventIn), .cfgOut(cfgOut), .preloadPulse(preloadPulse),
    .preloadValue(preloadValue), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] addr, input logic [31:0] data);
    @(negedge clk);
    busAddr = addr; busWe = 1'b1; busWdata = data;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] addr, output logic [31:0] data);
    @(negedge clk);
    busAddr = addr; busWe = 1'b0;
    @(negedge clk);
    data = busRdata;
  endtask

  task automatic pulseEvent(input logic [4:0] ev);
    @(negedge clk);
    eventIn = ev;
    @(negedge clk);
    eventIn = '0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    busRead(4'h0, v); check("R1 ctrl reset", v, 32'h0);
    busRead(4'h4, v); check("R1 status reset", v, 32'h0);
    busRead(4'h8, v); check("R1 data reset R12", v, 32'h0);
    check("R1 irq reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic testCtrlReadback();
    logic [31:0] v;
    busWrite(4'h0, 32'hFFFF_FFFF);
    busRead(4'h0, v); check("R2 ctrl all ones", v, 32'h0000_FEDF);
    check("R2 cfgOut", {16'b0, cfgOut}, 32'h0000_FEDF);
    busWrite(4'h0, 32'h0000_1234);
    busRead(4'h0, v); check("R2 ctrl pattern", v, 32'h0000_1214);
    busWrite(4'h0, 32'h0);
  endtask

  task automatic testDataReg();
    logic [31:0] v;
    busWrite(4'h8, 32'h5555_5555);
    busRead(4'h8, v); check("R5 data 55", v, 32'h5555_5555);
    busWrite(4'h8, 32'hAAAA_AAAA);
    busRead(4'h8, v); check("R5 data AA", v, 32'hAAAA_AAAA);
  endtask

  task automatic testLatch();
    logic [31:0] v;
    liveCount = 32'h1357_9BDF;
    busWrite(4'h0, 32'h0000_0100);
    liveCount = 32'h0;
    busRead(4'h0, v); check("R4 latch bit reads 0", v, 32'h0);
    busRead(4'h8, v); check("R4 latched count", v, 32'h1357_9BDF);
  endtask

  task automatic testPreload();
    busWrite(4'h8, 32'h0BAD_F00D);
    @(negedge clk);
    busAddr = 4'h0; busWe = 1'b1; busWdata = 32'h0000_0020;
    @(negedge clk);
    busWe = 1'b0;
    check("R3 preload pulse high", {31'b0, preloadPulse}, 32'h1);
    check("R3 preload value", preloadValue, 32'h0BAD_F00D);
    @(negedge clk);
    check("R3 preload pulse ends", {31'b0, preloadPulse}, 32'h0);
  endtask

  task automatic testStatus();
    logic [31:0] v;
    busWrite(4'h0, 32'h0);
    pulseEvent(5'b00110);
    busRead(4'h4, v); check("R6 flags set w/o enable", v, 32'h6);
    check("R8 irq low w/o enable", {31'b0, irq}, 32'h0);
    busWrite(4'h4, 32'h2);
    busRead(4'h4, v); check("R6 w1c clears only bit 1", v, 32'h4);
    busWrite(4'h0, 32'h0000_0040);
    check("R8 irq on enable", {31'b0, irq}, 32'h1);
    busWrite(4'h4, 32'h4);
    check("R8 irq drops on clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic testEventWins();
    logic [31:0] v;
    @(negedge clk);
    busAddr = 4'h4; busWe = 1'b1; busWdata = 32'h2; eventIn = 5'b00010;
    @(negedge clk);
    busWe = 1'b0; eventIn = '0;
    busRead(4'h4, v); check("R7 event beats clear", v, 32'h2);
    busWrite(4'h4, 32'h1F);
    busRead(4'h4, v); check("R7 later clear works", v, 32'h0);
  endtask

  task automatic testIrqMap();
    int enPos[5] = '{12, 7, 6, 4, 15};
    for (int i = 0; i < 5; i++) begin
      busWrite(4'h0, 32'(1) << enPos[(i + 1) % 5]);
      pulseEvent(5'(1) << i);
      check($sformatf("R8 other enable bit %0d", i), {31'b0, irq}, 32'h0);
      busWrite(4'h0, 32'(1) << enPos[i]);
      check($sformatf("R8 own enable bit %0d", i), {31'b0, irq}, 32'h1);
      busWrite(4'h4, 32'(1) << i);
      check($sformatf("R8 cleared bit %0d", i), {31'b0, irq}, 32'h0);
    end
    busWrite(4'h0, 32'h0);
  endtask

  task automatic testIndexHeld();
    logic [31:0] v;
    busWrite(4'h0, 32'h0000_0010);
    @(negedge clk);
    eventIn = 5'b01000;
    busWrite(4'h4, 32'h8);
    check("R9 irq stays with index held", {31'b0, irq}, 32'h1);
    busRead(4'h4, v); check("R9 flag re-set", v, 32'h8);
    @(negedge clk);
    eventIn = '0;
    busWrite(4'h4, 32'h8);
    check("R9 irq drops after release", {31'b0, irq}, 32'h0);
    busWrite(4'h0, 32'h0);
  endtask

  task automatic testIndexRead();
    logic [31:0] v;
    busWrite(4'h8, 32'h0000_0001);
    liveCount = 32'hCAFE_0001;
    pulseEvent(5'b01000);
    busRead(4'h8, v); check("R10 no capture when disabled", v, 32'h0000_0001);
    busWrite(4'h0, 32'h0000_2000);
    pulseEvent(5'b01000);
    busRead(4'h8, v); check("R10 index capture", v, 32'hCAFE_0001);
    busWrite(4'h4, 32'h1F);
    busWrite(4'h0, 32'h0);
    liveCount = 32'h0;
  endtask

  task automatic testUnmapped();
    logic [31:0] v;
    busWrite(4'h8, 32'h1234_5678);
    busWrite(4'hC, 32'hFFFF_FFFF);
    busWrite(4'h2, 32'hFFFF_FFFF);
    busRead(4'hC, v); check("R11 unmapped reads zero", v, 32'h0);
    busRead(4'h0, v); check("R11 ctrl untouched", v, 32'h0);
    busRead(4'h4, v); check("R11 status untouched", v, 32'h0);
    busRead(4'h8, v); check("R11 data untouched R12", v, 32'h1234_5678);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testCtrlReadback();
    testDataReg();
    testLatch();
    testPreload();
    testStatus();
    testEventWins();
    testIrqMap();
    testIndexHeld();
    testIndexRead();
    testUnmapped();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule